// File: doc/BRIEF.md
# Vertical-First Element Step Unit

This block performs the explicit element-advance operation of a vector engine running in vertical-first mode. In that mode every vector instruction works on one element only. A dedicated step command moves the source and destination element indices on to the next element. The unit holds both indices. It advances them together when a qualified step command arrives. When either index reaches the current vector length, both indices return to zero and vertical-first mode ends.

A step can carry a record flag. When it does, the unit writes a four-bit condition field. An immediate operand chooses what goes into that field. The field always reports whether the vector length was reached. It can also report the inner, middle and outer loop-end flags of one of several external loop-state sources. A separate input turns vertical-first mode on, and a synchronous reset clears all state.

All outputs are registered and change on the clock edge that follows the command.

Top module: `vf_step_unit`

## Requirements
- R1: While `rst` is high, at the next clock edge both step counters become 0, `vf_mode_o` becomes 0, `cr0_o` becomes 0 and `cr0_we_o` becomes 0.
- R2: `mode_set_i` high at a clock edge makes `vf_mode_o` 1 after that edge.
- R3: A step is accepted only when all of the following hold at the edge: `step_i`=1, `fld_vf_i`=1, `fld_vs_i`=0, `fld_ms_i`=0 and `vf_mode_o`=1. Any other step request leaves the counters, `cr0_o` and `vf_mode_o` unchanged, and `cr0_we_o` stays 0.
- R4: An accepted step without rollover increments `src_step_o` and `dst_step_o` by one each. Without an accepted step, both counters hold their value.
- R5: Rollover occurs when the incremented source step equals `vl_i`, or when the incremented destination step equals `vl_i`. The comparison uses the full value, with no wrap. On rollover both counters become 0 and `vf_mode_o` becomes 0.
- R6: When `mode_set_i` is high in the same cycle as a rollover, both counters still become 0 but `vf_mode_o` stays 1.
- R7: An accepted step with `rec_i`=1 drives `cr0_we_o` to 1 for one cycle and loads `cr0_o`. The field is {LT,GT,EQ,SO} in bits 3..0. SO is the rollover flag. For an immediate outside 2..5, LT, GT and EQ are 0.
- R8: With `rec_i`=1 and immediate value k in 2..5, the unit tests loop state j=k-2. That state's flags sit at `loop_end_i[3j+2:3j]` as {outer, middle, inner}. EQ takes inner, LT takes middle and GT takes outer, and SO is still the rollover flag.
- R9: An accepted step with `rec_i`=0 still advances the counters (R4, R5). `cr0_o` holds its previous value and `cr0_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_set_i | input | 1 | Turns vertical-first mode on |
| step_i | input | 1 | Step command strobe |
| fld_vf_i | input | 1 | Vertical-first field of the command |
| fld_vs_i | input | 1 | Set-length field of the command |
| fld_ms_i | input | 1 | Set-maximum field of the command |
| rec_i | input | 1 | Record flag: update the condition field |
| imm_i | input | IMM_W (7) | Immediate selecting the condition source |
| vl_i | input | CW (7) | Current vector length |
| loop_end_i | input | 3*N_STATES (12) | Loop-end flags {outer,middle,inner} per loop state |
| src_step_o | output | CW (7) | Source element step |
| dst_step_o | output | CW (7) | Destination element step |
| vf_mode_o | output | 1 | Vertical-first mode active |
| cr0_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr0_we_o | output | 1 | Condition field written this cycle |

## Verification
Two functions can land in the same cycle: a rollover that clears the mode, and a `mode_set_i` pulse that sets it. The bench provokes this by raising `mode_set_i` on the step that reaches `vl_i`. It then expects zeroed counters together with the mode still on. A random phase also overlaps set pulses, record steps, rejected field patterns and changes of `vl_i`. A behavioural reference model judges the mode bit, counters and condition field on every clock.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

   localparam int FLAGS_PER_STATE = 3;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cr0_t;

endpackage

// File: rtl/vfs_step_ctr.sv
module vfs_step_ctr #(
   parameter int CW         = 7,
   parameter bit SHARED_CMP = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic [CW-1:0] vl,
   output logic [CW-1:0] src,
   output logic [CW-1:0] dst,
   output logic          roll
);

   localparam int XW = CW + 1;

   logic [XW-1:0] src_inc;
   logic [XW-1:0] dst_inc;
   logic [XW-1:0] vl_x;

   assign src_inc = {1'b0, src} + XW'(1);
   assign dst_inc = {1'b0, dst} + XW'(1);
   assign vl_x    = {1'b0, vl};

   generate
      if (SHARED_CMP) begin : g_shared
         assign roll = (src_inc == vl_x);
      end else begin : g_dual
         logic hit_src;
         logic hit_dst;
         assign hit_src = (src_inc == vl_x);
         assign hit_dst = (dst_inc == vl_x);
         assign roll    = hit_src | hit_dst;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         src <= '0;
         dst <= '0;
      end else if (adv) begin
         if (roll) begin
            src <= '0;
            dst <= '0;
         end else begin
            src <= src_inc[CW-1:0];
            dst <= dst_inc[CW-1:0];
         end
      end
   end

endmodule

// File: rtl/vfs_cr_sel.sv
module vfs_cr_sel
   import vfs_pkg::*;
#(
   parameter int N_STATES = 4,
   parameter int IMM_W    = 7,
   parameter int SEL_BASE = 2
) (
   input  logic [IMM_W-1:0]                    imm,
   input  logic [FLAGS_PER_STATE*N_STATES-1:0] loop_end,
   input  logic                                roll,
   output cr0_t                                cr
);

   logic [N_STATES-1:0] hit;

   generate
      for (genvar k = 0; k < N_STATES; k++) begin : g_hit
         assign hit[k] = (imm == IMM_W'(SEL_BASE + k));
      end
   endgenerate

   always_comb begin
      cr    = '0;
      cr.so = roll;
      for (int k = 0; k < N_STATES; k++) begin
         if (hit[k]) begin
            cr.eq = loop_end[FLAGS_PER_STATE*k];
            cr.lt = loop_end[FLAGS_PER_STATE*k + 1];
            cr.gt = loop_end[FLAGS_PER_STATE*k + 2];
         end
      end
   end

endmodule

// File: rtl/vfs_mode_reg.sv
module vfs_mode_reg (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic mode
);

   always_ff @(posedge clk) begin
      if (rst)      mode <= 1'b0;
      else if (set) mode <= 1'b1;
      else if (clr) mode <= 1'b0;
   end

endmodule

// File: rtl/vf_step_unit.sv
module vf_step_unit
   import vfs_pkg::*;
#(
   parameter int CW         = 7,
   parameter int IMM_W      = 7,
   parameter int N_STATES   = 4,
   parameter int SEL_BASE   = 2,
   parameter bit SHARED_CMP = 1'b0
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                mode_set_i,
   input  logic                                step_i,
   input  logic                                fld_vf_i,
   input  logic                                fld_vs_i,
   input  logic                                fld_ms_i,
   input  logic                                rec_i,
   input  logic [IMM_W-1:0]                    imm_i,
   input  logic [CW-1:0]                       vl_i,
   input  logic [FLAGS_PER_STATE*N_STATES-1:0] loop_end_i,
   output logic [CW-1:0]                       src_step_o,
   output logic [CW-1:0]                       dst_step_o,
   output logic                                vf_mode_o,
   output logic [3:0]                          cr0_o,
   output logic                                cr0_we_o
);

   localparam int SEL_LAST = SEL_BASE + N_STATES - 1;

   generate
      if (CW < 1) begin : g_bad_cw
         $error("vf_step_unit: CW must be at least 1");
      end
      if (N_STATES < 1) begin : g_bad_states
         $error("vf_step_unit: N_STATES must be at least 1");
      end
      if (SEL_BASE < 1 || SEL_LAST >= (1 << IMM_W)) begin : g_bad_sel
         $error("vf_step_unit: selector range does not fit the immediate");
      end
   endgenerate

   logic accept;
   logic roll;
   cr0_t cr_next;
   cr0_t cr_q;

   assign accept = step_i & fld_vf_i & ~fld_vs_i & ~fld_ms_i & vf_mode_o;

   vfs_step_ctr #(
      .CW         (CW),
      .SHARED_CMP (SHARED_CMP)
   ) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .adv  (accept),
      .vl   (vl_i),
      .src  (src_step_o),
      .dst  (dst_step_o),
      .roll (roll)
   );

   vfs_cr_sel #(
      .N_STATES (N_STATES),
      .IMM_W    (IMM_W),
      .SEL_BASE (SEL_BASE)
   ) u_sel (
      .imm      (imm_i),
      .loop_end (loop_end_i),
      .roll     (roll),
      .cr       (cr_next)
   );

   vfs_mode_reg u_mode (
      .clk  (clk),
      .rst  (rst),
      .set  (mode_set_i),
      .clr  (accept & roll),
      .mode (vf_mode_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cr_q     <= '0;
         cr0_we_o <= 1'b0;
      end else begin
         cr0_we_o <= accept & rec_i;
         if (accept & rec_i) cr_q <= cr_next;
      end
   end

   assign cr0_o = cr_q;

endmodule

// File: rtl/vf_step_unit_chk.sv
module vf_step_unit_chk #(
   parameter int CW    = 7,
   parameter int IMM_W = 7,
   parameter int LEW   = 12
) (
   input logic             clk,
   input logic             rst,
   input logic             mode_set_i,
   input logic             step_i,
   input logic             fld_vf_i,
   input logic             fld_vs_i,
   input logic             fld_ms_i,
   input logic             rec_i,
   input logic [IMM_W-1:0] imm_i,
   input logic [CW-1:0]    vl_i,
   input logic [LEW-1:0]   loop_end_i,
   input logic [CW-1:0]    src_step_o,
   input logic [CW-1:0]    dst_step_o,
   input logic             vf_mode_o,
   input logic [3:0]       cr0_o,
   input logic             cr0_we_o
);

   logic ok_step;
   logic will_roll;
   logic low_sel;

   assign ok_step   = step_i & fld_vf_i & ~fld_vs_i & ~fld_ms_i & vf_mode_o;
   assign will_roll = (({1'b0, src_step_o} + 1'b1) == {1'b0, vl_i}) |
                      (({1'b0, dst_step_o} + 1'b1) == {1'b0, vl_i});
   assign low_sel   = (imm_i < IMM_W'(2)) | (imm_i > IMM_W'(5)) | (loop_end_i == '0);

   assert_set_mode_R2: assert property (@(posedge clk) disable iff (rst)
      mode_set_i |=> vf_mode_o);

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !ok_step |=> ($stable(src_step_o) && $stable(dst_step_o) && $stable(cr0_o) && !cr0_we_o));

   assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
      (ok_step && !will_roll) |=> (src_step_o == $past(src_step_o) + 1'b1) &&
                                  (dst_step_o == $past(dst_step_o) + 1'b1));

   assert_rollover_R5: assert property (@(posedge clk) disable iff (rst)
      (ok_step && will_roll && !mode_set_i) |=> (src_step_o == '0) && (dst_step_o == '0) && !vf_mode_o);

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
      (ok_step && will_roll && mode_set_i) |=> (src_step_o == '0) && vf_mode_o);

   assert_so_flag_R7: assert property (@(posedge clk) disable iff (rst)
      (ok_step && rec_i) |=> cr0_we_o && (cr0_o[0] == $past(will_roll)));

   assert_vl_only_R8: assert property (@(posedge clk) disable iff (rst)
      (ok_step && rec_i && low_sel) |=> (cr0_o[3:1] == 3'b000));

   assert_no_record_R9: assert property (@(posedge clk) disable iff (rst)
      (ok_step && !rec_i) |=> $stable(cr0_o) && !cr0_we_o);

endmodule

bind vf_step_unit vf_step_unit_chk #(
   .CW    (CW),
   .IMM_W (IMM_W),
   .LEW   (vfs_pkg::FLAGS_PER_STATE*N_STATES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .mode_set_i (mode_set_i),
   .step_i     (step_i),
   .fld_vf_i   (fld_vf_i),
   .fld_vs_i   (fld_vs_i),
   .fld_ms_i   (fld_ms_i),
   .rec_i      (rec_i),
   .imm_i      (imm_i),
   .vl_i       (vl_i),
   .loop_end_i (loop_end_i),
   .src_step_o (src_step_o),
   .dst_step_o (dst_step_o),
   .vf_mode_o  (vf_mode_o),
   .cr0_o      (cr0_o),
   .cr0_we_o   (cr0_we_o)
);

// File: tb/tb_vf_step_unit.sv
module tb_vf_step_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mode_set = 1'b0;
   logic        step = 1'b0;
   logic        fvf = 1'b0;
   logic        fvs = 1'b0;
   logic        fms = 1'b0;
   logic        rec = 1'b0;
   logic [6:0]  imm = '0;
   logic [6:0]  vl = 7'd4;
   logic [11:0] le = '0;
   logic [6:0]  src, dst;
   logic        mode;
   logic [3:0]  cr;
   logic        we;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;

   int m_src = 0, m_dst = 0, m_mode = 0, m_cr = 0, m_we = 0;

   always #10 clk = ~clk;

   vf_step_unit dut (
      .clk(clk), .rst(rst), .mode_set_i(mode_set), .step_i(step),
      .fld_vf_i(fvf), .fld_vs_i(fvs), .fld_ms_i(fms), .rec_i(rec),
      .imm_i(imm), .vl_i(vl), .loop_end_i(le),
      .src_step_o(src), .dst_step_o(dst), .vf_mode_o(mode),
      .cr0_o(cr), .cr0_we_o(we)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      if (rst) begin
         m_src = 0; m_dst = 0; m_mode = 0; m_cr = 0; m_we = 0;
      end else begin
         int ns, nd, j;
         bit acc, rl;
         acc = step && fvf && !fvs && !fms && (m_mode == 1);
         m_we = (acc && rec) ? 1 : 0;
         if (acc) begin
            ns = m_src + 1;
            nd = m_dst + 1;
            rl = (ns == int'(vl)) || (nd == int'(vl));
            if (rl) begin ns = 0; nd = 0; m_mode = 0; end
            m_src = ns % 128;
            m_dst = nd % 128;
            if (rec) begin
               m_cr = rl ? 1 : 0;
               if (imm >= 2 && imm <= 5) begin
                  j = int'(imm) - 2;
                  if (le[3*j])     m_cr += 2;
                  if (le[3*j + 2]) m_cr += 4;
                  if (le[3*j + 1]) m_cr += 8;
               end
            end
         end
         if (mode_set) m_mode = 1;
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R4 src", int'(src), m_src);
         chk("R4 dst", int'(dst), m_dst);
         chk("R5 mode", int'(mode), m_mode);
         chk("R8 cr0", int'(cr), m_cr);
         chk("R7 we", int'(we), m_we);
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_step(input bit r, input int im, input bit ms);
      step = 1; fvf = 1; fvs = 0; fms = 0; rec = r; imm = 7'(im); mode_set = ms;
      tick();
      step = 0; rec = 0; mode_set = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) tick();
      chk("R1 src", int'(src), 0);
      chk("R1 mode", int'(mode), 0);
      chk("R1 cr0", int'(cr), 0);
      rst = 0;
      cmp_en = 1;
      // R3: step while mode off is ignored
      do_step(1, 1, 0);
      chk("R3 mode off", int'(src), 0);
      chk("R3 we", int'(we), 0);
      // R2
      mode_set = 1; tick(); mode_set = 0;
      chk("R2 mode", int'(mode), 1);
      // R3: wrong field bits
      step = 1; fvf = 1; fvs = 1; tick(); step = 0; fvs = 0;
      chk("R3 vs set", int'(src), 0);
      step = 1; fvf = 0; tick(); step = 0;
      chk("R3 vf clear", int'(src), 0);
      // R4, R9
      vl = 7'd3;
      do_step(0, 1, 0);
      chk("R4 src 1", int'(src), 1);
      chk("R9 we", int'(we), 0);
      // R7: record imm=1, no rollover yet
      le = 12'hFFF;
      do_step(1, 1, 0);
      chk("R7 src 2", int'(src), 2);
      chk("R7 cr0", int'(cr), 0);
      chk("R7 we", int'(we), 1);
      // R5 + R8: rollover, imm=2 selects state 0 = {outer0,middle1,inner1}
      le = 12'b000_000_000_011;
      do_step(1, 2, 0);
      chk("R5 src", int'(src), 0);
      chk("R5 mode", int'(mode), 0);
      chk("R8 state0", int'(cr), 4'b1011);
      // R8: state 3 via imm=5, flags {outer1,middle0,inner1}
      mode_set = 1; tick(); mode_set = 0;
      vl = 7'd8;
      le = 12'b101_000_000_000;
      do_step(1, 5, 0);
      chk("R8 state3", int'(cr), 4'b0110);
      // R9: no record keeps cr0
      do_step(0, 3, 0);
      chk("R9 cr0 held", int'(cr), 4'b0110);
      chk("R9 src", int'(src), 2);
      // R6: rollover with simultaneous set
      vl = 7'd3;
      do_step(0, 1, 1);
      chk("R6 src", int'(src), 0);
      chk("R6 mode", int'(mode), 1);
      // mixed random phase
      for (int i = 0; i < 3000; i++) begin
         step     = ($urandom_range(0, 3) != 0);
         fvf      = ($urandom_range(0, 7) != 0);
         fvs      = ($urandom_range(0, 7) == 0);
         fms      = ($urandom_range(0, 7) == 0);
         rec      = $urandom_range(0, 1);
         imm      = 7'($urandom_range(0, 7));
         mode_set = ($urandom_range(0, 5) == 0);
         le       = 12'($urandom);
         if ($urandom_range(0, 15) == 0) vl = 7'($urandom_range(1, 8));
         tick();
      end
      step = 0; mode_set = 0;
      tick();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule